// File: doc/BRIEF.md
# Accumulator Bit-Field Extractor with Running Position

This block keeps four double-word accumulators and a 32-bit control word whose low six bits act as a running bit pointer into an accumulator. An extract operation pulls a field of programmable width out of the selected accumulator, with the field's top bit at the pointer, and returns it right-justified. When the pointer is too low for the requested width the extract fails: a non-sticky fail bit in the control word is raised and the returned value is zero. A decrementing extract moves the pointer down past the bits it consumed, and a move-high operation pushes the low word of an accumulator into its high word, loads a new word into the low half and moves the pointer up by 32. Together these allow a bit stream to be fed into an accumulator one word at a time and read back in fields of any size.

Software reads the control word at any time and may overwrite it. The other control fields (insert size, carry, sticky flags and condition bits) are held here and written by software only. Operations are issued one per cycle on a two-bit operation code. The extracted field and the control word are registered and change on the clock edge that ends the issuing cycle.

Top module: `acc_field_extract`

## Requirements
- R1: Four accumulators of 64 bits are addressed by the 2-bit `acc_sel_i`; an operation reads or changes only the selected accumulator.
- R2: Operation code 2'b01 (extract) or 2'b10 (decrementing extract) with pointer value p and size code s (0 to 31) sets `field_o` on the next edge to accumulator bits [p : p-s] placed at bits [s:0], with every higher bit zero; `field_o` keeps its value for op codes 2'b00 and 2'b11.
- R3: An extract fails when p is smaller than s: the fail bit (control bit 14, also `fail_o`) becomes 1, `field_o` becomes zero and the pointer is unchanged.
- R4: The fail bit is not sticky: every extract writes it (1 on failure, 0 on success), while op codes 2'b00 and 2'b11 leave it as it was.
- R5: A successful decrementing extract lowers the pointer by s+1 modulo 64; a failed one and a plain extract leave the pointer unchanged.
- R6: Operation code 2'b11 (move-high) copies the low 32 bits of the selected accumulator into its high 32 bits, loads `data_i` into the low 32 bits, and raises the pointer by 32 modulo 64.
- R7: With `ctl_we_i` high, `ctl_wdata_i` is stored on the next edge into the fields pointer [5:0], insert size [12:7], carry [13], fail [14], sticky flags [23:16] and condition bits [27:24].
- R8: Control bits 6, 15 and 31:28 always read zero, whatever is written.
- R9: When an operation and a control write share a cycle, the operation's new pointer (and, for extracts, its fail bit) wins over the written value; all other fields take the written value.
- R10: Reset (synchronous, active high) clears the control word and `field_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation: 00 idle, 01 extract, 10 decrementing extract, 11 move-high |
| acc_sel_i | input | 2 | Accumulator index |
| size_i | input | 5 | Field size code s; the field has s+1 bits |
| data_i | input | 32 | Word loaded into the low half by move-high |
| ctl_we_i | input | 1 | Control word write enable |
| ctl_wdata_i | input | 32 | Control word write data |
| field_o | output | 32 | Registered extracted field |
| fail_o | output | 1 | Extract fail bit (control bit 14) |
| pos_o | output | 6 | Current bit pointer |
| ctl_o | output | 32 | Full control word |

## Verification
The bench aims at the pointer edges: extraction with the pointer equal to the size (a design comparing with less-or-equal would fail it), a decrementing extract that wraps the pointer below zero to 63, a move-high that wraps past 63, and full 32-bit fields at the top of an accumulator where a wrong mask would leak or drop bits. It also checks that the fail bit stays through idle and move-high cycles and clears on the next good extract, which a sticky or a free-running implementation would get wrong, and it collides operations with control writes to show the pointer update taking priority. Random mixes of all four operations, accumulator selections and occasional writes are compared against a bench model after every cycle.

// File: rtl/afx_pkg.sv
package afx_pkg;
  typedef enum logic [1:0] {
    OP_IDLE   = 2'b00,
    OP_EXT    = 2'b01,
    OP_EXT_DN = 2'b10,
    OP_MV_HI  = 2'b11
  } afx_op_e;

  localparam int CTL_W    = 32;
  localparam int FAIL_BIT = 14;
  localparam logic [CTL_W-1:0] CTL_WMASK = 32'h0FFF_7FBF;
endpackage

// File: rtl/afx_acc_bank.sv
module afx_acc_bank #(
  parameter int DATA_W = 32,
  parameter int N_ACC  = 4,
  localparam int ACC_W = 2 * DATA_W,
  localparam int SEL_W = $clog2(N_ACC)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [DATA_W-1:0] lo_in,
  output logic [ACC_W-1:0] rdata
);
  logic [ACC_W-1:0] mem [N_ACC];

  assign rdata = mem[sel];

  // Move-high: old low word shifts up, new word enters at the bottom.
  always_ff @(posedge clk) begin
    if (we) mem[sel] <= {rdata[DATA_W-1:0], lo_in};
  end
endmodule

// File: rtl/afx_extract.sv
module afx_extract #(
  parameter int DATA_W = 32,
  localparam int ACC_W  = 2 * DATA_W,
  localparam int POS_W  = $clog2(ACC_W),
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic [ACC_W-1:0]  acc,
  input  logic [POS_W-1:0]  pos,
  input  logic [SIZE_W-1:0] size,
  output logic [DATA_W-1:0] field,
  output logic              fail
);
  localparam logic [DATA_W-1:0] ONES = '1;

  logic [POS_W-1:0]  size_x;
  logic [POS_W-1:0]  lsb;
  logic [ACC_W-1:0]  shifted;
  logic [DATA_W-1:0] mask;

  always_comb begin
    size_x  = POS_W'(size);
    fail    = pos < size_x;
    lsb     = pos - size_x;
    shifted = acc >> lsb;
    mask    = ONES >> (SIZE_W'(DATA_W - 1) - size);
    field   = fail ? '0 : (shifted[DATA_W-1:0] & mask);
  end
endmodule

// File: rtl/afx_ctrl.sv
module afx_ctrl
  import afx_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int ACC_W  = 2 * DATA_W,
  localparam int POS_W  = $clog2(ACC_W),
  localparam int SIZE_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTL_W-1:0]  wdata,
  input  logic [1:0]        op,
  input  logic [SIZE_W-1:0] size,
  input  logic              ext_fail,
  output logic [CTL_W-1:0]  ctl
);
  localparam logic [POS_W-1:0] HALF = POS_W'(DATA_W);

  logic [CTL_W-1:0] ctl_nx;
  logic [POS_W-1:0] pos_q;
  logic             is_ext;

  assign pos_q  = ctl[POS_W-1:0];
  assign is_ext = (op == OP_EXT) || (op == OP_EXT_DN);

  always_comb begin
    ctl_nx = ctl;
    if (we) ctl_nx = wdata & CTL_WMASK;
    if (is_ext) ctl_nx[FAIL_BIT] = ext_fail;
    if (op == OP_EXT_DN && !ext_fail)
      ctl_nx[POS_W-1:0] = pos_q - POS_W'(size) - POS_W'(1);
    else if (op == OP_MV_HI)
      ctl_nx[POS_W-1:0] = pos_q + HALF;
    else if (is_ext)
      ctl_nx[POS_W-1:0] = pos_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl <= '0;
    else     ctl <= ctl_nx;
  end

  a_r3_short_sets_fail: assert property (@(posedge clk) disable iff (rst)
    (is_ext && (pos_q < POS_W'(size))) |=> ctl[FAIL_BIT]);

  a_r4_fail_kept_without_extract: assert property (@(posedge clk) disable iff (rst)
    (!is_ext && !we) |=> $stable(ctl[FAIL_BIT]));

  a_r5_down_step: assert property (@(posedge clk) disable iff (rst)
    (op == OP_EXT_DN && pos_q >= POS_W'(size)) |=>
      ctl[POS_W-1:0] == POS_W'($past(pos_q) - $past(POS_W'(size)) - 1));

  a_r6_up_step: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MV_HI) |=> ctl[POS_W-1:0] == POS_W'($past(pos_q) + HALF));

  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (ctl[6] == 1'b0 && ctl[15] == 1'b0 && ctl[31:28] == 4'h0));
endmodule

// File: rtl/acc_field_extract.sv
module acc_field_extract
  import afx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_ACC  = 4,
  localparam int ACC_W  = 2 * DATA_W,
  localparam int POS_W  = $clog2(ACC_W),
  localparam int SIZE_W = $clog2(DATA_W),
  localparam int SEL_W  = $clog2(N_ACC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [SEL_W-1:0]  acc_sel_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  output logic [DATA_W-1:0] field_o,
  output logic              fail_o,
  output logic [POS_W-1:0]  pos_o,
  output logic [CTL_W-1:0]  ctl_o
);
  logic [ACC_W-1:0]  acc_rd;
  logic [DATA_W-1:0] ext_field;
  logic              ext_fail;
  logic              is_ext;

  assign is_ext = (op_i == OP_EXT) || (op_i == OP_EXT_DN);

  afx_acc_bank #(.DATA_W(DATA_W), .N_ACC(N_ACC)) u_bank (
    .clk   (clk),
    .we    (op_i == OP_MV_HI),
    .sel   (acc_sel_i),
    .lo_in (data_i),
    .rdata (acc_rd)
  );

  afx_extract #(.DATA_W(DATA_W)) u_ext (
    .acc   (acc_rd),
    .pos   (pos_o),
    .size  (size_i),
    .field (ext_field),
    .fail  (ext_fail)
  );

  afx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we       (ctl_we_i),
    .wdata    (ctl_wdata_i),
    .op       (op_i),
    .size     (size_i),
    .ext_fail (ext_fail),
    .ctl      (ctl_o)
  );

  always_ff @(posedge clk) begin
    if (rst)         field_o <= '0;
    else if (is_ext) field_o <= ext_field;
  end

  assign fail_o = ctl_o[FAIL_BIT];
  assign pos_o  = ctl_o[POS_W-1:0];

  a_r3_failed_field_zero: assert property (@(posedge clk) disable iff (rst)
    (is_ext && pos_o < POS_W'(size_i)) |=> (field_o == '0 && fail_o));

  a_r2_field_held: assert property (@(posedge clk) disable iff (rst)
    (!is_ext) |=> $stable(field_o));

  a_r2_field_width: assert property (@(posedge clk) disable iff (rst)
    is_ext |=> ((field_o >> ($past(size_i) + 1'b1)) == '0 || $past(size_i) == SIZE_W'(DATA_W - 1)));
endmodule

// File: tb/test_acc_field_extract.sv
`timescale 1ns/1ps
module test_acc_field_extract;
  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  op = 0;
  logic [1:0]  sel = 0;
  logic [4:0]  size = 0;
  logic [31:0] data = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] field_o;
  logic        fail_o;
  logic [5:0]  pos_o;
  logic [31:0] ctl_o;

  int errors = 0;
  int checks = 0;

  logic [63:0] m_acc [4];
  logic [31:0] m_ctl;
  logic [31:0] m_field;

  always #2 clk = ~clk;

  acc_field_extract i_acc_field_extract (
    .clk(clk), .rst(rst), .op_i(op), .acc_sel_i(sel), .size_i(size),
    .data_i(data), .ctl_we_i(we), .ctl_wdata_i(wdata),
    .field_o(field_o), .fail_o(fail_o), .pos_o(pos_o), .ctl_o(ctl_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  // Reference: field bits [p : p-s], right-justified.
  function automatic logic [31:0] ref_field(input logic [63:0] a, input int p, input int s);
    logic [31:0] r = '0;
    for (int i = 0; i <= s; i++) r[i] = a[p - s + i];
    return r;
  endfunction

  task automatic step(input string req, input logic [1:0] o, input logic [1:0] sl,
                      input logic [4:0] sz, input logic [31:0] d,
                      input logic w, input logic [31:0] wd);
    int p;
    logic [31:0] nctl;
    @(negedge clk);
    op = o; sel = sl; size = sz; data = d; we = w; wdata = wd;
    p = int'(m_ctl[5:0]);
    nctl = w ? (wd & 32'h0FFF_7FBF) : m_ctl;
    if (o == 2'b01 || o == 2'b10) begin
      if (p < int'(sz)) begin
        nctl[14] = 1'b1; nctl[5:0] = m_ctl[5:0]; m_field = '0;
      end else begin
        nctl[14] = 1'b0;
        m_field = ref_field(m_acc[sl], p, int'(sz));
        nctl[5:0] = (o == 2'b10) ? 6'(p - int'(sz) - 1) : m_ctl[5:0];
      end
    end else if (o == 2'b11) begin
      nctl[5:0] = 6'(p + 32);
      m_acc[sl] = {m_acc[sl][31:0], d};
    end
    m_ctl = nctl;
    @(posedge clk); #1;
    op = 0; we = 0;
    chk({req, " field"}, field_o, m_field);
    chk({req, " ctl"}, ctl_o, m_ctl);
    chk({req, " fail"}, {31'd0, fail_o}, {31'd0, m_ctl[14]});
    chk({req, " pos"}, {26'd0, pos_o}, {26'd0, m_ctl[5:0]});
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0042);
    m_ctl = 0; m_field = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R10 reset state
    chk("R10 ctl", ctl_o, 32'h0);
    chk("R10 field", field_o, 32'h0);

    // R6 / R1: load all four accumulators with distinct words
    for (int a = 0; a < 4; a++) begin
      step("R6 load", 2'b11, 2'(a), 0, 32'hA000_0000 + 32'(a) * 32'h1111_1111, 0, 0);
      step("R6 load", 2'b11, 2'(a), 0, 32'h0F0F_0000 ^ (32'(a) << 8) ^ 32'h1234, 0, 0);
    end
    // R7 / R8: write all ones
    step("R7 R8 write", 2'b00, 0, 0, 0, 1, 32'hFFFF_FFFF);
    chk("R8 value", ctl_o, 32'h0FFF_7FBF);
    // R2: full 32-bit field from the top of acc1
    step("R2 top word", 2'b01, 2'd1, 5'd31, 0, 0, 0);
    chk("R2 direct", field_o, 32'hB111_1111);
    // R1: acc0 untouched by loads of others
    step("R1 acc0", 2'b01, 2'd0, 5'd31, 0, 0, 0);
    // R3: pointer below size
    step("R3 set pos", 2'b00, 0, 0, 0, 1, 32'd5);
    step("R3 short", 2'b01, 2'd2, 5'd10, 0, 0, 0);
    chk("R3 direct fail", {31'd0, fail_o}, 32'd1);
    // R4: fail survives idle and move-high, clears on success
    step("R4 idle", 2'b00, 0, 0, 0, 0, 0);
    step("R4 mvhi", 2'b11, 2'd3, 0, 32'hDEAD_BEEF, 0, 0);
    step("R4 clear", 2'b01, 2'd3, 5'd3, 0, 0, 0);
    chk("R4 direct clear", {31'd0, fail_o}, 32'd0);
    // R3 boundary: pos equal to size succeeds; R5 wraps below zero
    step("R5 set pos", 2'b00, 0, 0, 0, 1, 32'd7);
    step("R5 wrap", 2'b10, 2'd0, 5'd7, 0, 0, 0);
    chk("R5 direct wrap", {26'd0, pos_o}, 32'd63);
    step("R5 step", 2'b10, 2'd0, 5'd4, 0, 0, 0);
    chk("R5 direct step", {26'd0, pos_o}, 32'd58);
    step("R5 fail keeps", 2'b00, 0, 0, 0, 1, 32'd2);
    step("R5 fail keeps", 2'b10, 2'd0, 5'd9, 0, 0, 0);
    // R6 wrap above 63
    step("R6 wrap set", 2'b00, 0, 0, 0, 1, 32'd40);
    step("R6 wrap", 2'b11, 2'd2, 0, 32'h1357_9BDF, 0, 0);
    chk("R6 direct", {26'd0, pos_o}, 32'd8);
    // R9: collisions
    step("R9 mvhi+write", 2'b11, 2'd1, 0, 32'h2468_ACE0, 1, 32'h0A55_0011);
    step("R9 ext+write", 2'b10, 2'd1, 5'd2, 0, 1, 32'h0155_4020);
    step("R9 fail+write", 2'b01, 2'd1, 5'd20, 0, 1, 32'h0000_0004);

    // Random mix R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R2/R4/R5/R6/R9 random", r[1:0], r[3:2], 5'($urandom_range(0, 31)), $urandom,
           (r[7:5] == 3'd0), (r[8] ? 32'($urandom_range(0, 63)) : $urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule